// File: doc/BRIEF.md
# Striped Parity Array Controller

This block turns single-block host reads and writes into accesses on N data storage ports plus one redundant port. Logical blocks are laid out stripe by stripe, with one parity block per stripe. Each storage port is a synchronous block memory behind a request/acknowledge handshake. The parity block's port can stay fixed on the last port, or it can move from stripe to stripe so that parity updates are spread over the whole array.

Only one host request is in flight at a time. A write updates parity with a read-modify-write, which needs no access to the other data blocks of the stripe. One port can be flagged as failed. Reads of its blocks are then rebuilt from the rest of the stripe. Writes to it are folded into the parity block, and writes whose parity port is failed store only the data. Two or more failed ports put the controller into a sticky error state.

Top module: `stripe_parity_ctrl`

## Requirements
- R1: After reset, host_busy, host_done and host_err are low and no port request is raised.
- R2: For logical block address A: stripe = A / N, which is also the address presented to every port. Slot = A mod N. The data port is the slot when the slot is below the parity port index, and the slot plus one otherwise.
- R3: With cfg_rotate high, the parity port of stripe s is N − (s mod (N+1)). With cfg_rotate low, the parity port is always port N.
- R4: With no port failed, a write makes exactly four port accesses, one at a time and in this order: read old data, read old parity, write new data, write new parity.
- R5: The parity written by a write equals old parity XOR old data XOR new data. This keeps the XOR of all N+1 blocks of the stripe at zero.
- R6: A read whose data port is healthy makes one access, on that port only, and returns the stored block on host_rdata while host_done is high.
- R7: A read whose data port is failed reads every surviving port of the stripe, in ascending port order, and returns the XOR of those blocks. The failed port is never accessed.
- R8: A write whose data port is failed reads every surviving port in ascending order and then writes only the recomputed parity. A later rebuilt read of that block returns the new data.
- R9: A write whose parity port is failed makes one access, a write of the new data to its data port.
- R10: host_done is a one-cycle pulse that comes two cycles after each port access, counted from the accepting clock edge: 2 × (number of accesses) cycles in total. host_busy is high in between. A request raised while busy is ignored.
- R11: If two or more bits of fail_mask are set, host_err rises on the next clock and stays high until reset. While it is high, requests cause no port access and no host_done.
- R12: A port request keeps its address, direction and write data stable until that port acknowledges. The acknowledge is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rotate | input | 1 | 1: parity rotates per stripe, 0: parity on port N |
| fail_mask | input | N+1 | One bit per port, set for a failed port |
| host_req | input | 1 | Request strobe, sampled while idle |
| host_we | input | 1 | 1 write, 0 read |
| host_lba | input | LBA_W | Logical block address |
| host_wdata | input | DW | Block to write |
| host_busy | output | 1 | A request is in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | DW | Read result, valid with host_done |
| host_err | output | 1 | Sticky multi-failure error |
| prt_req | output | N+1 | Per-port access request |
| prt_we | output | N+1 | Per-port write enable |
| prt_addr | output | (N+1)×LBA_W | Per-port stripe address |
| prt_wdata | output | (N+1)×DW | Per-port write data |
| prt_ack | input | N+1 | Per-port acknowledge pulse |
| prt_rdata | input | (N+1)×DW | Per-port read data, valid with acknowledge |

## Verification
Two functions can meet in the same cycle. The first case is a host request that arrives while a read-modify-write is still in progress. The bench raises host_req with a different address two cycles after acceptance and checks that no extra port access appears and that the completion time stays at eight cycles. The second case is a failure flag that covers a block being written. There the parity update and the rebuild happen together: the survivors are swept, only parity is written, and a rebuilt read that follows must return the new block. A scoreboard predicts every port access and result from the address arithmetic and from a shadow copy of the logical data.

// File: rtl/spa_pkg.sv
`timescale 1ns/1ps
package spa_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_RD_D  = 3'd1,
        S_RD_P  = 3'd2,
        S_WR_D  = 3'd3,
        S_WR_P  = 3'd4,
        S_SWEEP = 3'd5
    } spa_state_e;
endpackage

// File: rtl/spa_map.sv
`timescale 1ns/1ps
module spa_map #(
    parameter int N     = 4,
    parameter int LBA_W = 6,
    parameter int IW    = 3
) (
    input  logic [LBA_W-1:0] lba,
    input  logic             rotate,
    output logic [LBA_W-1:0] stripe,
    output logic [IW-1:0]    dport,
    output logic [IW-1:0]    pport
);
    localparam logic [LBA_W-1:0] NL  = LBA_W'(N);
    localparam logic [LBA_W-1:0] NPL = LBA_W'(N + 1);

    logic [LBA_W-1:0] slot_w, srot_w;
    logic [IW-1:0]    slot;

    always_comb begin
        stripe = lba / NL;
        slot_w = lba % NL;
        srot_w = stripe % NPL;
        slot   = IW'(slot_w);
        // rotation: parity walks downward from the last port
        pport  = rotate ? IW'(NL - srot_w) : IW'(N);
        dport  = (slot < pport) ? slot : slot + IW'(1);
    end
endmodule

// File: rtl/spa_portmux.sv
`timescale 1ns/1ps
module spa_portmux #(
    parameter int NP = 5,
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int IW = 3
) (
    input  logic                   act_en,
    input  logic [IW-1:0]          act_port,
    input  logic                   act_we,
    input  logic [AW-1:0]          act_addr,
    input  logic [DW-1:0]          act_wdata,
    output logic [NP-1:0]          prt_req,
    output logic [NP-1:0]          prt_we,
    output logic [NP-1:0][AW-1:0]  prt_addr,
    output logic [NP-1:0][DW-1:0]  prt_wdata,
    input  logic [NP-1:0]          prt_ack,
    input  logic [NP-1:0][DW-1:0]  prt_rdata,
    output logic                   sel_ack,
    output logic [DW-1:0]          sel_rdata
);
    logic [NP-1:0] hit;

    for (genvar g = 0; g < NP; g++) begin : g_port
        assign hit[g]       = act_en && (act_port == IW'(g));
        assign prt_req[g]   = hit[g];
        assign prt_we[g]    = hit[g] && act_we;
        assign prt_addr[g]  = hit[g] ? act_addr  : '0;
        assign prt_wdata[g] = (hit[g] && act_we) ? act_wdata : '0;
    end

    always_comb begin
        sel_ack   = 1'b0;
        sel_rdata = '0;
        for (int i = 0; i < NP; i++) begin
            if (hit[i]) begin
                sel_ack   = prt_ack[i];
                sel_rdata = prt_rdata[i];
            end
        end
    end
endmodule

// File: rtl/spa_seq.sv
`timescale 1ns/1ps
module spa_seq
    import spa_pkg::*;
#(
    parameter int N  = 4,
    parameter int NP = 5,
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int IW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NP-1:0]   fail_mask,
    input  logic            host_req,
    input  logic            host_we,
    input  logic [DW-1:0]   host_wdata,
    input  logic [AW-1:0]   map_stripe,
    input  logic [IW-1:0]   map_dport,
    input  logic [IW-1:0]   map_pport,
    input  logic            sel_ack,
    input  logic [DW-1:0]   sel_rdata,
    output logic            act_en,
    output logic [IW-1:0]   act_port,
    output logic            act_we,
    output logic [AW-1:0]   act_addr,
    output logic [DW-1:0]   act_wdata,
    output logic            busy,
    output logic            done,
    output logic [DW-1:0]   rdata,
    output logic            err
);
    typedef struct packed {
        spa_state_e      st;
        logic [AW-1:0]   stripe;
        logic [IW-1:0]   dport;
        logic [IW-1:0]   pport;
        logic [IW-1:0]   cur;
        logic            we;
        logic [DW-1:0]   wnew;
        logic [DW-1:0]   acc;
        logic [DW-1:0]   oldd;
        logic [DW-1:0]   oldp;
        logic [DW-1:0]   rdata;
        logic [NP-1:0]   fail;
        logic            done;
        logic            err;
    } seq_t;

    seq_t q, d;
    logic multi;
    logic [IW:0] nx;

    // lowest healthy port at or above 'from'; top bit set when none
    function automatic logic [IW:0] next_alive(input logic [NP-1:0] msk, input int from);
        logic [IW:0] r;
        r = {1'b1, {IW{1'b0}}};
        for (int j = NP - 1; j >= 0; j--) begin
            if (j >= from && !msk[j]) r = {1'b0, IW'(j)};
        end
        return r;
    endfunction

    always_comb begin
        d      = q;
        d.done = 1'b0;
        multi  = ($countones(fail_mask) > 1);
        d.err  = q.err | multi;
        nx     = '0;
        unique case (q.st)
            S_IDLE: begin
                if (host_req && !q.err && !multi) begin
                    d.stripe = map_stripe;
                    d.dport  = map_dport;
                    d.pport  = map_pport;
                    d.we     = host_we;
                    d.wnew   = host_wdata;
                    d.fail   = fail_mask;
                    d.acc    = '0;
                    d.oldd   = '0;
                    d.oldp   = '0;
                    if (fail_mask[map_dport]) begin
                        nx    = next_alive(fail_mask, 0);
                        d.cur = nx[IW-1:0];
                        d.st  = S_SWEEP;
                    end else if (host_we && fail_mask[map_pport]) begin
                        d.cur = map_dport;
                        d.st  = S_WR_D;
                    end else begin
                        d.cur = map_dport;
                        d.st  = S_RD_D;
                    end
                end
            end
            S_RD_D: begin
                if (sel_ack) begin
                    d.oldd = sel_rdata;
                    if (!q.we) begin
                        d.rdata = sel_rdata;
                        d.done  = 1'b1;
                        d.st    = S_IDLE;
                    end else begin
                        d.cur = q.pport;
                        d.st  = S_RD_P;
                    end
                end
            end
            S_RD_P: begin
                if (sel_ack) begin
                    d.oldp = sel_rdata;
                    d.cur  = q.dport;
                    d.st   = S_WR_D;
                end
            end
            S_WR_D: begin
                if (sel_ack) begin
                    if (q.fail[q.pport]) begin
                        d.done = 1'b1;
                        d.st   = S_IDLE;
                    end else begin
                        d.cur = q.pport;
                        d.st  = S_WR_P;
                    end
                end
            end
            S_WR_P: begin
                if (sel_ack) begin
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end
            end
            S_SWEEP: begin
                if (sel_ack) begin
                    d.acc = q.acc ^ sel_rdata;
                    if (q.cur == q.pport) d.oldp = sel_rdata;
                    nx = next_alive(q.fail, int'(q.cur) + 1);
                    if (nx[IW]) begin
                        if (!q.we) begin
                            d.rdata = q.acc ^ sel_rdata;
                            d.done  = 1'b1;
                            d.st    = S_IDLE;
                        end else begin
                            d.oldd = q.acc ^ sel_rdata;
                            d.cur  = q.pport;
                            d.st   = S_WR_P;
                        end
                    end else begin
                        d.cur = nx[IW-1:0];
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign act_en    = (q.st != S_IDLE);
    assign act_port  = q.cur;
    assign act_we    = (q.st == S_WR_D) || (q.st == S_WR_P);
    assign act_addr  = q.stripe;
    assign act_wdata = (q.st == S_WR_D) ? q.wnew : (q.oldp ^ q.oldd ^ q.wnew);
    assign busy      = (q.st != S_IDLE);
    assign done      = q.done;
    assign rdata     = q.rdata;
    assign err       = q.err;

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n) (act_en && !sel_ack) |=> (act_en && $stable(act_port) && $stable(act_we) && $stable(act_wdata))); // R12
    AST_SKIP_FAILED: assert property (@(posedge clk) disable iff (!rst_n) act_en |-> !q.fail[act_port]); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err |=> err); // R11
    AST_REJECT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n) (err && !busy) |=> !busy); // R11
    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(sel_ack)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
endmodule

// File: rtl/stripe_parity_ctrl.sv
`timescale 1ns/1ps
module stripe_parity_ctrl #(
    parameter int N     = 4,
    parameter int DW    = 16,
    parameter int LBA_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_rotate,
    input  logic [N:0]               fail_mask,
    input  logic                     host_req,
    input  logic                     host_we,
    input  logic [LBA_W-1:0]         host_lba,
    input  logic [DW-1:0]            host_wdata,
    output logic                     host_busy,
    output logic                     host_done,
    output logic [DW-1:0]            host_rdata,
    output logic                     host_err,
    output logic [N:0]               prt_req,
    output logic [N:0]               prt_we,
    output logic [N:0][LBA_W-1:0]    prt_addr,
    output logic [N:0][DW-1:0]       prt_wdata,
    input  logic [N:0]               prt_ack,
    input  logic [N:0][DW-1:0]       prt_rdata
);
    localparam int NP = N + 1;
    localparam int IW = (NP > 1) ? $clog2(NP) : 1;

    logic [LBA_W-1:0] map_stripe;
    logic [IW-1:0]    map_dport, map_pport;
    logic             act_en, act_we, sel_ack;
    logic [IW-1:0]    act_port;
    logic [LBA_W-1:0] act_addr;
    logic [DW-1:0]    act_wdata, sel_rdata;

    spa_map #(.N(N), .LBA_W(LBA_W), .IW(IW)) u_map (
        .lba    (host_lba),
        .rotate (cfg_rotate),
        .stripe (map_stripe),
        .dport  (map_dport),
        .pport  (map_pport)
    );

    spa_seq #(.N(N), .NP(NP), .AW(LBA_W), .DW(DW), .IW(IW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fail_mask  (fail_mask),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .map_stripe (map_stripe),
        .map_dport  (map_dport),
        .map_pport  (map_pport),
        .sel_ack    (sel_ack),
        .sel_rdata  (sel_rdata),
        .act_en     (act_en),
        .act_port   (act_port),
        .act_we     (act_we),
        .act_addr   (act_addr),
        .act_wdata  (act_wdata),
        .busy       (host_busy),
        .done       (host_done),
        .rdata      (host_rdata),
        .err        (host_err)
    );

    spa_portmux #(.NP(NP), .AW(LBA_W), .DW(DW), .IW(IW)) u_mux (
        .act_en    (act_en),
        .act_port  (act_port),
        .act_we    (act_we),
        .act_addr  (act_addr),
        .act_wdata (act_wdata),
        .prt_req   (prt_req),
        .prt_we    (prt_we),
        .prt_addr  (prt_addr),
        .prt_wdata (prt_wdata),
        .prt_ack   (prt_ack),
        .prt_rdata (prt_rdata),
        .sel_ack   (sel_ack),
        .sel_rdata (sel_rdata)
    );
endmodule

// File: tb/tb_stripe_parity_ctrl.sv
`timescale 1ns/1ps
module tb_stripe_parity_ctrl;
    localparam int N = 4, DW = 16, LBA_W = 6;
    localparam int NP = N + 1, DEP = 1 << LBA_W;

    typedef struct { int port; bit we; int addr; logic [DW-1:0] wd; string req; } acc_t;
    typedef struct { bit is_rd; logic [DW-1:0] val; string req; } res_t;

    logic clk = 1'b0, rst_n = 1'b0, cfg_rotate = 1'b1, mclr = 1'b1;
    logic [N:0] fail_mask = '0;
    logic host_req = 1'b0, host_we = 1'b0;
    logic [LBA_W-1:0] host_lba = '0;
    logic [DW-1:0] host_wdata = '0;
    logic host_busy, host_done, host_err;
    logic [DW-1:0] host_rdata;
    logic [N:0] prt_req, prt_we, ack;
    logic [N:0][LBA_W-1:0] prt_addr;
    logic [N:0][DW-1:0] prt_wdata, rdat;
    logic [DW-1:0] mem [NP][DEP];
    logic [DW-1:0] lg [DEP];
    acc_t exp_acc[$];
    res_t exp_res[$];
    int checks = 0, errors = 0, seen = 0;
    bit finished = 0;
    logic [N:0] last_req;
    logic [N:0][LBA_W-1:0] last_addr;

    always #2.5 clk = ~clk;

    stripe_parity_ctrl #(.N(N), .DW(DW), .LBA_W(LBA_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_rotate(cfg_rotate), .fail_mask(fail_mask),
        .host_req(host_req), .host_we(host_we), .host_lba(host_lba), .host_wdata(host_wdata),
        .host_busy(host_busy), .host_done(host_done), .host_rdata(host_rdata), .host_err(host_err),
        .prt_req(prt_req), .prt_we(prt_we), .prt_addr(prt_addr), .prt_wdata(prt_wdata),
        .prt_ack(ack), .prt_rdata(rdat)
    );

    // storage ports: acknowledge one cycle after a request, as a single pulse
    always @(posedge clk) begin
        if (mclr) begin
            for (int p = 0; p < NP; p++) begin
                for (int a = 0; a < DEP; a++) mem[p][a] <= '0;
            end
            ack <= '0;
            rdat <= '0;
        end else begin
            for (int p = 0; p < NP; p++) begin
                if (prt_req[p] && !ack[p]) begin
                    ack[p]  <= 1'b1;
                    rdat[p] <= mem[p][prt_addr[p]];
                    if (prt_we[p]) mem[p][prt_addr[p]] <= prt_wdata[p];
                end else begin
                    ack[p] <= 1'b0;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic int f_pp(input int s, input bit rot);
        return rot ? (N - (s % NP)) : N;
    endfunction

    function automatic int f_dp(input int lba, input bit rot);
        int pp, slot;
        pp = f_pp(lba / N, rot);
        slot = lba % N;
        return (slot < pp) ? slot : slot + 1;
    endfunction

    // monitor: every completed port access is popped against the prediction
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < NP; p++) begin
                if (prt_req[p] && ack[p]) begin
                    seen++;
                    if (last_req[p]) chk("R12 address held until ack", 32'(prt_addr[p]), 32'(last_addr[p]));
                    if (exp_acc.size() == 0) begin
                        chk("R4 unexpected port access", 32'(p), 32'hFFFF);
                    end else begin
                        acc_t e;
                        e = exp_acc.pop_front();
                        chk({e.req, " port"}, 32'(p), 32'(e.port));
                        chk({e.req, " direction"}, 32'(prt_we[p]), 32'(e.we));
                        chk({e.req, " stripe address"}, 32'(prt_addr[p]), 32'(e.addr));
                        if (e.we) chk({e.req, " write data"}, 32'(prt_wdata[p]), 32'(e.wd));
                    end
                end
            end
            if (host_done) begin
                if (exp_res.size() == 0) begin
                    chk("R10 unexpected done", 32'(host_done), 32'h0);
                end else begin
                    res_t r;
                    r = exp_res.pop_front();
                    if (r.is_rd) chk({r.req, " read data"}, 32'(host_rdata), 32'(r.val));
                end
            end
        end
        last_req  = prt_req & ~ack;
        last_addr = prt_addr;
    end

    task automatic push_acc(input int p, input bit we, input int s, input logic [DW-1:0] wd, input string req);
        acc_t e;
        e.port = p; e.we = we; e.addr = s; e.wd = wd; e.req = req;
        exp_acc.push_back(e);
    endtask

    // driver: predicts accesses and result, then issues the request
    task automatic op(input bit we, input int lba, input logic [DW-1:0] wd, input bit poke);
        int s, dp, pp, nacc, cnt;
        bit rot, dfail, pfail;
        logic [DW-1:0] par;
        string tag;
        res_t r;
        rot = cfg_rotate;
        s = lba / N;
        dp = f_dp(lba, rot);
        pp = f_pp(s, rot);
        dfail = fail_mask[dp];
        pfail = fail_mask[pp];
        if (!we) begin
            if (!dfail) begin
                push_acc(dp, 0, s, '0, "R2");
                tag = "R6";
            end else begin
                for (int p = 0; p < NP; p++) if (!fail_mask[p]) push_acc(p, 0, s, '0, "R7");
                tag = "R7";
            end
            r.is_rd = 1; r.val = lg[lba]; r.req = tag;
        end else begin
            lg[lba] = wd;
            par = '0;
            for (int k = 0; k < N; k++) par ^= lg[s * N + k];
            if (dfail) begin
                for (int p = 0; p < NP; p++) if (!fail_mask[p]) push_acc(p, 0, s, '0, "R8");
                push_acc(pp, 1, s, par, "R8");
                tag = "R8";
            end else if (pfail) begin
                push_acc(dp, 1, s, wd, "R9");
                tag = "R9";
            end else begin
                push_acc(dp, 0, s, '0, "R2");
                push_acc(pp, 0, s, '0, "R3");
                push_acc(dp, 1, s, wd, "R2");
                push_acc(pp, 1, s, par, "R5");
                tag = "R4";
            end
            r.is_rd = 0; r.val = '0; r.req = tag;
        end
        exp_res.push_back(r);
        nacc = exp_acc.size();
        seen = 0;
        host_we = we; host_lba = LBA_W'(lba); host_wdata = wd; host_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0;
        cnt = 0;
        while (!host_done && cnt < 100) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (cnt == 1) chk("R10 busy during operation", 32'(host_busy), 32'h1);
            host_req = (poke && cnt == 2);
            if (poke && cnt == 2) host_lba = LBA_W'(lba ^ 1);
        end
        host_req = 1'b0;
        chk("R10 completion latency", 32'(cnt), 32'(2 * nacc));
        chk({tag, " access count"}, 32'(seen), 32'(nacc));
        @(posedge clk);
        @(negedge clk);
        chk("R10 done is one pulse", 32'(host_done), 32'h0);
        chk("R10 idle after done", 32'(host_busy), 32'h0);
    endtask

    task automatic restart(input bit rot);
        rst_n = 1'b0; mclr = 1'b1; fail_mask = '0; cfg_rotate = rot;
        for (int i = 0; i < DEP; i++) lg[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 busy at reset", 32'(host_busy), 32'h0);
        chk("R1 done at reset", 32'(host_done), 32'h0);
        chk("R1 err at reset", 32'(host_err), 32'h0);
        chk("R1 no port request", 32'(prt_req), 32'h0);
        rst_n = 1'b1; mclr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        int tgt;
        restart(1'b1);
        // rotated parity across stripes 0..5, one write poked while busy
        for (int a = 0; a < 24; a++) op(1'b1, a, DW'(16'h1357 + a * 16'h0a3d), (a == 5));
        for (int a = 0; a < 24; a++) op(1'b0, a, '0, 1'b0);
        for (int a = 0; a < 8; a++) op(1'b1, a, DW'(16'hbeef ^ (a * 16'h0111)), 1'b0);
        // port 2 failed: rebuilt reads, folded writes
        fail_mask = 5'b00100;
        for (int a = 0; a < 24; a++) op(1'b0, a, '0, 1'b0);
        tgt = -1;
        for (int a = 4; a < 24; a++) if (tgt < 0 && f_dp(a, 1'b1) == 2) tgt = a;
        op(1'b1, tgt, 16'hc0de, 1'b0);
        op(1'b0, tgt, '0, 1'b0);
        op(1'b1, (tgt / N) * N + ((tgt % N + 1) % N), 16'h5a5a, 1'b0);
        op(1'b0, tgt, '0, 1'b0);
        // parity port of stripe 0 failed
        fail_mask = '0;
        fail_mask[f_pp(0, 1'b1)] = 1'b1;
        op(1'b1, 1, 16'h7777, 1'b0);
        // fixed parity placement
        restart(1'b0);
        for (int a = 0; a < 12; a++) op(1'b1, a, DW'(16'h2468 + a * 16'h1111), (a == 3));
        for (int a = 0; a < 12; a++) op(1'b0, a, '0, 1'b0);
        // two failures: sticky error, requests rejected
        fail_mask = 5'b00011;
        @(posedge clk);
        @(negedge clk);
        chk("R11 error raised", 32'(host_err), 32'h1);
        host_we = 1'b0; host_lba = 6'd3; host_req = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            @(negedge clk);
            host_req = 1'b0;
            chk("R11 request rejected (busy)", 32'(host_busy), 32'h0);
            chk("R11 request rejected (done)", 32'(host_done), 32'h0);
        end
        fail_mask = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11 error sticky", 32'(host_err), 32'h1);
        restart(1'b1);
        chk("R11 error cleared by reset", 32'(host_err), 32'h0);
        finish_up();
    end
endmodule